// File: doc/BRIEF.md
# Byte-wide memory enable decoder

This block sits between a processor's access request and a byte-wide static RAM bus. Each request carries a 16-bit address, a flag that says whether it is an instruction fetch or a data access, and a write flag. From these and a few steady configuration pins, the block decides where the access goes. It can go to one of four 32 KB RAM blocks, to a single 128 KB RAM, to one of four memory-mapped peripheral quarters of data space, or to the external expanded bus. It then drives the matching active-low enable for a fixed number of clocks, together with the write strobe and the low 15 address bits.

Requests arrive on a valid/ready handshake. The block accepts at most one access per pulse. `req_ready` stays low for as long as a pulse is running and for as long as the hold input is high. A requester that sees ready low must keep `req_valid` and the request fields steady until ready returns, and the access is taken on the clock edge where both are high.

A physical RAM index of 17 bits is formed for each RAM access. Bit 16 is the space bit (0 for the program half, 1 for the data half) and bits 15..0 are the address. In the dynamic-boundary mode both spaces share the program half. Every output comes from a register, so the enables change only on clock edges.

Top module: `bwmem_decode`

## Requirements
- R1: `req_ready` is high only when no enable pulse is running and `hold_i` is low. An access is taken on a rising edge where `req_valid` and `req_ready` are both high. No access is taken while `hold_i` is high.
- R2: The outputs of a taken access appear in the cycle after the accepting edge and hold for exactly PULSE_CLKS cycles (default 4). Then every enable returns high, `ext_bus` goes low and `req_ready` rises again.
- R3: With `bank32_sel`=1, a RAM access drives `ce_n[k]` low, where k is physical bits 16..15. The other three enables stay high.
- R4: With `bank32_sel`=0 (one 128 KB RAM), a RAM access drives `ce_n[0]` low. During the pulse, `ce_n[1]` carries physical bit 16 and `ce_n[2]` carries physical bit 15. `ce_n[3]` is never driven low.
- R5: A data access with `periph_en`=1 drives `pe_n[addr[15:14]]` low and leaves every `ce_n` high. Instruction fetches ignore `periph_en`.
- R6: In fixed mapping, an access is mapped to RAM when its address is below 2^(10+c), where c is `win_code` clamped to 6. The physical space bit is 0 for fetches and 1 for data.
- R7: In dynamic-boundary mode (`part_en`=1 and `bank32_sel`=1), the boundary is `part_limit`×4096. Fetches below the boundary go to RAM and all other fetches do not. Every data access goes to RAM, and both spaces use physical space bit 0.
- R8: When `bank32_sel`=0, `part_en` has no effect and the fixed mapping of R6 applies.
- R9: `rw_n` is low during a pulse only for a data write to a writable target. Writable targets are a RAM data access at or above the boundary in dynamic mode, any data access in fixed mode, and any peripheral access. Fetches never drive `rw_n` low.
- R10: An access that maps to neither RAM nor a peripheral raises `ext_bus` for the pulse, with every enable high and `rw_n` high.
- R11: From the first clock edge at which `hold_i` is high, every `ce_n`, every `pe_n`, `ce1b_n` and `rw_n` are high and `ext_bus` is low. Any running pulse is cut short.
- R12: `ce1b_n` always equals `ce_n[0]`.
- R13: During a pulse, `bw_addr` equals bits 14..0 of the accepted address.
- R14: After reset, every enable is high, `rw_n` is high, `ext_bus` is low and `req_ready` is high while `hold_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Reset or power-fail hold; forces all strobes inactive |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request can be taken |
| req_addr | input | 16 | Access address |
| req_data | input | 1 | 1 = data space, 0 = instruction fetch |
| req_wr | input | 1 | 1 = write |
| bank32_sel | input | 1 | 1 = four 32 KB RAMs, 0 = one 128 KB RAM |
| periph_en | input | 1 | Route data space to the peripheral quarters |
| part_en | input | 1 | Dynamic program/data boundary mode |
| part_limit | input | 4 | Boundary in 4 KB units |
| win_code | input | 3 | Fixed-mapping window size code |
| ce_n | output | 4 | RAM chip enables, active low (or high address bits in 128 KB mode) |
| ce1b_n | output | 1 | Second copy of chip enable 1 for non-backed devices |
| pe_n | output | 4 | Peripheral quarter enables, active low |
| rw_n | output | 1 | Write strobe, low = write |
| ext_bus | output | 1 | Access routed to the expanded bus |
| bw_addr | output | 15 | Byte-wide address bits 14..0 |

## Verification
The assertions rely on three conditions. `bank32_sel`, `periph_en`, `part_en`, `part_limit` and `win_code` stay steady from the accepting edge until the pulse ends. Request fields stay steady while `req_valid` waits on a low `req_ready`. Any pulse not ended by `hold_i` therefore runs its full length. The stimulus changes configuration only at falling edges when no pulse is running, drops `req_valid` right after the accepting edge, and raises `hold_i` both in the middle of a pulse and while a request is waiting.

// File: rtl/bwmem_pkg.sv
package bwmem_pkg;
  localparam int unsigned SPACE_AW = 16;
  localparam int unsigned PHYS_AW  = SPACE_AW + 1;

  typedef enum logic [1:0] {
    TGT_EXT    = 2'd0,
    TGT_RAM    = 2'd1,
    TGT_PERIPH = 2'd2
  } tgt_e;
endpackage

// File: rtl/bwmem_route.sv
module bwmem_route import bwmem_pkg::*; #(
  parameter int unsigned PB_W        = 4,
  parameter int unsigned WIN_CODE_W  = 3,
  parameter int unsigned WIN_MIN_LOG = 10
) (
  input  logic [SPACE_AW-1:0]   addr,
  input  logic                  is_data,
  input  logic                  is_wr,
  input  logic                  bank32,
  input  logic                  periph_en,
  input  logic                  part_en,
  input  logic [PB_W-1:0]       part_limit,
  input  logic [WIN_CODE_W-1:0] win_code,
  output tgt_e                  tgt,
  output logic [PHYS_AW-1:0]    phys,
  output logic                  wr_ok
);
  localparam int unsigned SH_W = $clog2(SPACE_AW + 1);
  localparam logic [WIN_CODE_W-1:0] WIN_MAX_C = WIN_CODE_W'(SPACE_AW - WIN_MIN_LOG);
  localparam logic [SPACE_AW:0] ONE_L = 1;

  logic [SH_W-1:0]   shift;
  logic [SPACE_AW:0] win_lim;
  logic [SPACE_AW:0] bound;
  logic              part_live;
  logic              below_bound;
  logic              in_window;

  // window size: 2^(min+code), clamped to the whole space
  always_comb begin
    if (win_code > WIN_MAX_C) shift = SH_W'(SPACE_AW);
    else                      shift = SH_W'(WIN_MIN_LOG) + SH_W'(win_code);
    win_lim   = ONE_L << shift;
    in_window = {1'b0, addr} < win_lim;
  end

  // dynamic boundary is only honoured with four separate banks
  always_comb begin
    part_live   = part_en & bank32;
    bound       = {1'b0, part_limit, {(SPACE_AW - PB_W){1'b0}}};
    below_bound = {1'b0, addr} < bound;
  end

  always_comb begin
    tgt   = TGT_EXT;
    phys  = {1'b0, addr};
    wr_ok = 1'b0;
    if (periph_en && is_data) begin
      tgt   = TGT_PERIPH;
      wr_ok = is_wr;
    end else if (part_live) begin
      if (is_data) begin
        tgt   = TGT_RAM;
        wr_ok = is_wr && !below_bound;
      end else if (below_bound) begin
        tgt = TGT_RAM;
      end
    end else begin
      phys = {is_data, addr};
      if (in_window) begin
        tgt   = TGT_RAM;
        wr_ok = is_wr && is_data;
      end
    end
  end
endmodule

// File: rtl/bwmem_enables.sv
module bwmem_enables import bwmem_pkg::*; #(
  parameter int unsigned NBANK = 4,
  parameter int unsigned NQUAD = 4,
  localparam int unsigned BLK_W = $clog2(NBANK),
  localparam int unsigned QD_W  = $clog2(NQUAD)
) (
  input  tgt_e             tgt,
  input  logic             bank32,
  input  logic [BLK_W-1:0] blk,
  input  logic [QD_W-1:0]  quad,
  output logic [NBANK-1:0] ce_n,
  output logic [NQUAD-1:0] pe_n,
  output logic             ext
);
  logic is_ram;
  logic is_pe;
  logic [NBANK-1:0] ce_sep_n;
  logic [NBANK-1:0] ce_big_n;

  assign is_ram = (tgt == TGT_RAM);
  assign is_pe  = (tgt == TGT_PERIPH);
  assign ext    = (tgt == TGT_EXT);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign ce_sep_n[g] = ~(is_ram && (blk == BLK_W'(g)));
    if (g == 0) begin : g_sel
      assign ce_big_n[g] = ~is_ram;
    end else if (g == 1) begin : g_hi
      assign ce_big_n[g] = is_ram ? blk[BLK_W-1] : 1'b1;
    end else if (g == 2) begin : g_lo
      assign ce_big_n[g] = is_ram ? blk[0] : 1'b1;
    end else begin : g_off
      assign ce_big_n[g] = 1'b1;
    end
  end

  assign ce_n = bank32 ? ce_sep_n : ce_big_n;

  for (genvar q = 0; q < NQUAD; q++) begin : g_quad
    assign pe_n[q] = ~(is_pe && (quad == QD_W'(q)));
  end
endmodule

// File: rtl/bwmem_pulse.sv
module bwmem_pulse #(
  parameter int unsigned PULSE_CLKS = 4,
  parameter int unsigned NBANK      = 4,
  parameter int unsigned NQUAD      = 4,
  parameter int unsigned BW_W       = 15,
  localparam int unsigned CNT_W = $clog2(PULSE_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [NBANK-1:0] ce_n_d,
  input  logic [NQUAD-1:0] pe_n_d,
  input  logic             rw_n_d,
  input  logic             ext_d,
  input  logic [BW_W-1:0]  bw_d,
  input  logic             bank32_d,
  output logic [NBANK-1:0] ce_n,
  output logic             ce1b_n,
  output logic [NQUAD-1:0] pe_n,
  output logic             rw_n,
  output logic             ext_bus,
  output logic [BW_W-1:0]  bw_addr
);
  logic [CNT_W-1:0] cnt;
  logic             bank32_q;
  logic             fire;

  assign req_ready = (cnt == '0) && !hold;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      ce_n     <= '1;
      ce1b_n   <= 1'b1;
      pe_n     <= '1;
      rw_n     <= 1'b1;
      ext_bus  <= 1'b0;
      bw_addr  <= '0;
      bank32_q <= 1'b1;
    end else if (hold) begin
      cnt     <= '0;
      ce_n    <= '1;
      ce1b_n  <= 1'b1;
      pe_n    <= '1;
      rw_n    <= 1'b1;
      ext_bus <= 1'b0;
    end else if (fire) begin
      cnt      <= CNT_W'(PULSE_CLKS);
      ce_n     <= ce_n_d;
      ce1b_n   <= ce_n_d[0];
      pe_n     <= pe_n_d;
      rw_n     <= rw_n_d;
      ext_bus  <= ext_d;
      bw_addr  <= bw_d;
      bank32_q <= bank32_d;
    end else if (cnt == CNT_W'(1)) begin
      cnt     <= '0;
      ce_n    <= '1;
      ce1b_n  <= 1'b1;
      pe_n    <= '1;
      rw_n    <= 1'b1;
      ext_bus <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(hold) |-> (&ce_n) && (&pe_n) && rw_n && ce1b_n && !ext_bus); // R11

  AST_BIG_NO_CE4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) && !bank32_q |-> ce_n[NBANK-1]); // R4
endmodule

// File: rtl/bwmem_decode.sv
module bwmem_decode import bwmem_pkg::*; #(
  parameter int unsigned PULSE_CLKS  = 4,
  parameter int unsigned PB_W        = 4,
  parameter int unsigned WIN_CODE_W  = 3,
  parameter int unsigned WIN_MIN_LOG = 10,
  parameter int unsigned NBANK       = 4,
  parameter int unsigned NQUAD       = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hold_i,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [15:0]           req_addr,
  input  logic                  req_data,
  input  logic                  req_wr,
  input  logic                  bank32_sel,
  input  logic                  periph_en,
  input  logic                  part_en,
  input  logic [PB_W-1:0]       part_limit,
  input  logic [WIN_CODE_W-1:0] win_code,
  output logic [NBANK-1:0]      ce_n,
  output logic                  ce1b_n,
  output logic [NQUAD-1:0]      pe_n,
  output logic                  rw_n,
  output logic                  ext_bus,
  output logic [14:0]           bw_addr
);
  localparam int unsigned BLK_W = $clog2(NBANK);
  localparam int unsigned QD_W  = $clog2(NQUAD);
  localparam int unsigned BW_W  = PHYS_AW - BLK_W;
  localparam int unsigned LEN_W = $clog2(PULSE_CLKS + 2);

  tgt_e               tgt;
  logic [PHYS_AW-1:0] phys;
  logic               wr_ok;
  logic [NBANK-1:0]   ce_n_d;
  logic [NQUAD-1:0]   pe_n_d;
  logic               ext_d;

  bwmem_route #(
    .PB_W(PB_W), .WIN_CODE_W(WIN_CODE_W), .WIN_MIN_LOG(WIN_MIN_LOG)
  ) route_i (
    .addr(req_addr), .is_data(req_data), .is_wr(req_wr), .bank32(bank32_sel),
    .periph_en(periph_en), .part_en(part_en), .part_limit(part_limit),
    .win_code(win_code), .tgt(tgt), .phys(phys), .wr_ok(wr_ok)
  );

  bwmem_enables #(.NBANK(NBANK), .NQUAD(NQUAD)) enables_i (
    .tgt(tgt), .bank32(bank32_sel),
    .blk(phys[PHYS_AW-1 -: BLK_W]), .quad(req_addr[SPACE_AW-1 -: QD_W]),
    .ce_n(ce_n_d), .pe_n(pe_n_d), .ext(ext_d)
  );

  bwmem_pulse #(
    .PULSE_CLKS(PULSE_CLKS), .NBANK(NBANK), .NQUAD(NQUAD), .BW_W(BW_W)
  ) pulse_i (
    .clk(clk), .rst_n(rst_n), .hold(hold_i), .req_valid(req_valid),
    .req_ready(req_ready), .ce_n_d(ce_n_d), .pe_n_d(pe_n_d), .rw_n_d(~wr_ok),
    .ext_d(ext_d), .bw_d(phys[BW_W-1:0]), .bank32_d(bank32_sel),
    .ce_n(ce_n), .ce1b_n(ce1b_n), .pe_n(pe_n), .rw_n(rw_n),
    .ext_bus(ext_bus), .bw_addr(bw_addr)
  );

  // port-level checks
  logic             armed;
  logic             act;
  logic [LEN_W-1:0] len;

  assign act = (~&ce_n) || (~&pe_n) || ext_bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      len   <= '0;
    end else begin
      armed <= 1'b1;
      if (!act)           len <= '0;
      else if (~&len)     len <= len + LEN_W'(1);
    end
  end

  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $fell(act) && !$past(hold_i) |-> len == LEN_W'(PULSE_CLKS)); // R2

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> !req_ready); // R1

  AST_RW_NEEDS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_n |-> !ext_bus && ((~&ce_n) || (~&pe_n))); // R9

  AST_EXT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_bus |-> (&ce_n) && (&pe_n)); // R10

  AST_PE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~pe_n)); // R5

  AST_CE1_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    ce1b_n == ce_n[0]); // R12
endmodule

// File: tb/bwmem_decode_tb.sv
module bwmem_decode_tb_top;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold_i = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_data = 1'b0;
  logic        req_wr = 1'b0;
  logic        bank32_sel = 1'b1;
  logic        periph_en = 1'b0;
  logic        part_en = 1'b0;
  logic [3:0]  part_limit = '0;
  logic [2:0]  win_code = 3'd6;
  logic [3:0]  ce_n;
  logic        ce1b_n;
  logic [3:0]  pe_n;
  logic        rw_n;
  logic        ext_bus;
  logic [14:0] bw_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bwmem_decode dut_i (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_data(req_data),
    .req_wr(req_wr), .bank32_sel(bank32_sel), .periph_en(periph_en),
    .part_en(part_en), .part_limit(part_limit), .win_code(win_code),
    .ce_n(ce_n), .ce1b_n(ce1b_n), .pe_n(pe_n), .rw_n(rw_n),
    .ext_bus(ext_bus), .bw_addr(bw_addr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_state(input string req, input logic exp_ready);
    chk(req, "ce_n idle", 32'(ce_n), 32'hF);
    chk(req, "pe_n idle", 32'(pe_n), 32'hF);
    chk(req, "rw_n idle", 32'(rw_n), 32'h1);
    chk(req, "ce1b_n idle", 32'(ce1b_n), 32'h1);
    chk(req, "ext_bus idle", 32'(ext_bus), 32'h0);
    chk(req, "req_ready", 32'(req_ready), 32'(exp_ready));
  endtask

  // one access; samples every falling edge of the pulse and the one after
  task automatic access(input logic [15:0] a, input logic d, input logic w,
                        input logic [3:0] exp_ce, input logic [3:0] exp_pe,
                        input logic exp_rw, input logic exp_ext, input string req);
    chk("R1", "ready before access", 32'(req_ready), 32'h1);
    req_addr = a; req_data = d; req_wr = w; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (i != 0) @(negedge clk);
      chk(req, "ce_n", 32'(ce_n), 32'(exp_ce));
      chk(req, "pe_n", 32'(pe_n), 32'(exp_pe));
      chk(req, "rw_n", 32'(rw_n), 32'(exp_rw));
      chk(req, "ext_bus", 32'(ext_bus), 32'(exp_ext));
      chk("R13", "bw_addr", 32'(bw_addr), 32'(a[14:0]));
      chk("R12", "ce1b_n", 32'(ce1b_n), 32'(exp_ce[0]));
      chk("R1", "ready in pulse", 32'(req_ready), 32'h0);
    end
    @(negedge clk);
    idle_state("R2", 1'b1);
  endtask

  task automatic set_cfg(input logic b32, input logic pe, input logic pt,
                         input logic [3:0] lim, input logic [2:0] win);
    bank32_sel = b32; periph_en = pe; part_en = pt; part_limit = lim; win_code = win;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_state("R14", 1'b1);
  endtask

  task automatic t_banks();
    set_cfg(1'b1, 1'b0, 1'b0, 4'd0, 3'd6);
    access(16'h1234, 1'b0, 1'b0, 4'b1110, 4'hF, 1'b1, 1'b0, "R3");
    access(16'h9ABC, 1'b0, 1'b0, 4'b1101, 4'hF, 1'b1, 1'b0, "R3");
    access(16'h0042, 1'b1, 1'b1, 4'b1011, 4'hF, 1'b0, 1'b0, "R3");
    access(16'hF000, 1'b1, 1'b0, 4'b0111, 4'hF, 1'b1, 1'b0, "R3");
    access(16'h0010, 1'b0, 1'b1, 4'b1110, 4'hF, 1'b1, 1'b0, "R9");
  endtask

  task automatic t_window();
    set_cfg(1'b1, 1'b0, 1'b0, 4'd0, 3'd2);
    access(16'h0FFF, 1'b1, 1'b0, 4'b1011, 4'hF, 1'b1, 1'b0, "R6");
    access(16'h1000, 1'b1, 1'b1, 4'hF, 4'hF, 1'b1, 1'b1, "R10");
    access(16'h2000, 1'b0, 1'b0, 4'hF, 4'hF, 1'b1, 1'b1, "R10");
    win_code = 3'd0;
    access(16'h03FF, 1'b1, 1'b0, 4'b1011, 4'hF, 1'b1, 1'b0, "R6");
    access(16'h0400, 1'b1, 1'b0, 4'hF, 4'hF, 1'b1, 1'b1, "R6");
    win_code = 3'd7;
    access(16'hFFFF, 1'b0, 1'b0, 4'b1101, 4'hF, 1'b1, 1'b0, "R6");
  endtask

  task automatic t_big();
    set_cfg(1'b0, 1'b0, 1'b0, 4'd0, 3'd6);
    access(16'h1234, 1'b0, 1'b0, 4'b1000, 4'hF, 1'b1, 1'b0, "R4");
    access(16'hC001, 1'b1, 1'b0, 4'b1110, 4'hF, 1'b1, 1'b0, "R4");
    access(16'h8000, 1'b1, 1'b1, 4'b1110, 4'hF, 1'b0, 1'b0, "R4");
    access(16'h4000, 1'b1, 1'b0, 4'b1010, 4'hF, 1'b1, 1'b0, "R4");
    access(16'h8000, 1'b0, 1'b0, 4'b1100, 4'hF, 1'b1, 1'b0, "R4");
  endtask

  task automatic t_part_ignored();
    set_cfg(1'b0, 1'b0, 1'b1, 4'd2, 3'd6);
    access(16'h3000, 1'b0, 1'b0, 4'b1000, 4'hF, 1'b1, 1'b0, "R8");
    access(16'h0100, 1'b1, 1'b1, 4'b1010, 4'hF, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_part();
    set_cfg(1'b1, 1'b0, 1'b1, 4'd4, 3'd6);
    access(16'h3FFF, 1'b0, 1'b0, 4'b1110, 4'hF, 1'b1, 1'b0, "R7");
    access(16'h4000, 1'b0, 1'b0, 4'hF, 4'hF, 1'b1, 1'b1, "R7");
    access(16'h8000, 1'b1, 1'b0, 4'b1101, 4'hF, 1'b1, 1'b0, "R7");
    access(16'h2000, 1'b1, 1'b1, 4'b1110, 4'hF, 1'b1, 1'b0, "R9");
    access(16'h4000, 1'b1, 1'b1, 4'b1110, 4'hF, 1'b0, 1'b0, "R9");
  endtask

  task automatic t_periph();
    set_cfg(1'b1, 1'b1, 1'b0, 4'd0, 3'd6);
    access(16'h0005, 1'b1, 1'b1, 4'hF, 4'b1110, 1'b0, 1'b0, "R5");
    access(16'h5000, 1'b1, 1'b0, 4'hF, 4'b1101, 1'b1, 1'b0, "R5");
    access(16'hA000, 1'b1, 1'b0, 4'hF, 4'b1011, 1'b1, 1'b0, "R5");
    access(16'hFFFF, 1'b1, 1'b0, 4'hF, 4'b0111, 1'b1, 1'b0, "R5");
    access(16'h0005, 1'b0, 1'b0, 4'b1110, 4'hF, 1'b1, 1'b0, "R5");
  endtask

  task automatic t_hold();
    set_cfg(1'b1, 1'b0, 1'b0, 4'd0, 3'd6);
    req_addr = 16'hF000; req_data = 1'b1; req_wr = 1'b1; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11", "ce_n before hold", 32'(ce_n), 32'h7);
    chk("R11", "rw_n before hold", 32'(rw_n), 32'h0);
    @(negedge clk);
    hold_i = 1'b1;
    @(negedge clk);
    idle_state("R11", 1'b0);
    req_addr = 16'h0042; req_data = 1'b1; req_wr = 1'b1; req_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      idle_state("R11", 1'b0);
    end
    req_valid = 1'b0;
    hold_i = 1'b0;
    #1;
    chk("R1", "ready after hold", 32'(req_ready), 32'h1);
    @(negedge clk);
    idle_state("R1", 1'b1);
    access(16'h0042, 1'b1, 1'b1, 4'b1011, 4'hF, 1'b0, 1'b0, "R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_banks();
    t_window();
    t_big();
    t_part_ignored();
    t_part();
    t_periph();
    t_hold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule